// File: doc/BRIEF.md
# Scope-Aware Selective Self-Invalidation Controller

This controller manages the tag state of an intermediate shared cache in a clustered hierarchy. Each line holds two classification bits. One gives the line's sharing status among the cores of this cluster (the inner view). The other gives its status as seen from the level above (the outer view). A line that is inner-private also records which local core owns it. When a core issues a synchronization, the controller scans the tag array one set per cycle. It clears only the lines that the classification rules mark as possibly stale. A clean line is cleared at once. A dirty line is first written back to the parent, and it is cleared only after the parent acknowledges the write.

Read lookups come from the local cores. A lookup either hits locally, misses, or is forwarded to the next level. It is forwarded when a core other than the recorded owner touches a line that is inner-private but outer-shared. After such a forwarded read, the line is promoted to shared in both views. The scope of a synchronization comes only from the requesting core's ID. Line fills come in through a plain write port that models responses from the parent.

Top module: `scope_selfinv_ctrl`

## Requirements
- R1: After reset every line is invalid, so any lookup reports miss. `sync_ready` is 1, and `wb_req`, `rd_ack` and `sync_done` are all 0.
- R2: A line whose outer bit says private (`ext_shared`=0) stays valid through any synchronization. This holds whatever its inner bit and owner are, and whether or not it is dirty.
- R3: A line that is inner-private and outer-shared is cleared by an in-scope synchronization only when the local index of the synchronizing core equals the line's owner.
- R4: A line that is shared in both views is cleared by every in-scope synchronization.
- R5: A lookup is answered in `rd_kind` with 0 = local hit, 1 = forward to parent, 2 = miss. A lookup that matches a valid line which is inner-private and outer-shared answers 1 when `rd_core` differs from the owner. Every other matching lookup answers 0.
- R6: After a forward answer, the line is shared in both views. Later lookups by any core then hit, and the next in-scope synchronization from any core clears the line.
- R7: A synchronization is in scope when the upper bits of `sync_core` (above log2(LOCAL_CORES)) equal `CLUSTER_ID`, and the lower bits give the local index. An out-of-scope synchronization changes no line and raises `sync_done` at the accepting clock edge.
- R8: An in-scope synchronization with no dirty victims raises `sync_done` SETS edges after the accepting edge (one set per cycle). The pulse lasts one cycle, and the controller is idle again while it is high.
- R9: `rd_ready` is 0 for a lookup whose set is the one the scan currently holds. This includes the time spent waiting for a writeback. Lookups to other sets are accepted.
- R10: A dirty line chosen for clearing raises `wb_req` with its set and tag. These are held stable until `wb_ack`. The line is cleared only after that acknowledge. Clean victims never cause a writeback.
- R11: A lookup whose tag matches no valid line in its set answers 2 (miss). The response kind is never 3.
- R12: `rd_ack` is high, with the answer, in exactly the cycle after the cycle in which a lookup was accepted (`rd_valid` and `rd_ready`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fill_valid | input | 1 | Install a line this cycle |
| fill_set | input | SET_W | Set index of the installed line |
| fill_way | input | WAY_W | Way of the installed line |
| fill_tag | input | TAG_W | Tag of the installed line |
| fill_int_shared | input | 1 | Inner classification, 1 = shared |
| fill_ext_shared | input | 1 | Outer classification, 1 = shared |
| fill_owner | input | OWN_W | Local owner index for inner-private lines |
| fill_dirty | input | 1 | Line holds modified data |
| rd_valid | input | 1 | Lookup request |
| rd_core | input | OWN_W | Local index of the requesting core |
| rd_set | input | SET_W | Lookup set |
| rd_tag | input | TAG_W | Lookup tag |
| rd_ready | output | 1 | Lookup can be accepted |
| rd_ack | output | 1 | Lookup answer valid |
| rd_kind | output | 2 | 0 hit, 1 forward, 2 miss |
| sync_req | input | 1 | Synchronization request |
| sync_core | input | CORE_W | Global ID of the synchronizing core |
| sync_ready | output | 1 | Controller idle, request can be taken |
| sync_done | output | 1 | One-cycle pulse at the end of a synchronization |
| wb_req | output | 1 | Writeback of a dirty victim pending |
| wb_set | output | SET_W | Set of the victim |
| wb_tag | output | TAG_W | Tag of the victim |
| wb_ack | input | 1 | Parent accepted the writeback |

## Verification
The bench sweeps every combination of inner bit, outer bit and owner against every core ID of both clusters. For each combination it checks whether the line survives a synchronization. A design that clears outer-private lines, ignores the owner test, or ignores the cluster bits of the ID fails specific points of that sweep. A second sweep pairs each classification with each reading core. It checks the forward answer and also the promotion that follows it. A design that forwards but does not promote gives a forward answer where a hit is expected, and it keeps the line across a non-owner synchronization. A stalled writeback checks that the victim's set and tag stay held, that lookups to that set are refused, and that a dirty outer-private neighbour is neither written back nor dropped.

// File: rtl/ssi_pkg.sv
package ssi_pkg;

    // Answer codes on rd_kind
    typedef enum logic [1:0] {
        RK_HIT  = 2'd0,
        RK_FWD  = 2'd1,
        RK_MISS = 2'd2
    } rd_kind_e;

    // Scan sequencer states
    typedef enum logic [1:0] {
        SC_IDLE  = 2'd0,
        SC_SCAN  = 2'd1,
        SC_FLUSH = 2'd2
    } scan_e;

endpackage

// File: rtl/ssi_scope_decode.sv
// Splits a global core ID into a cluster match and a local index.
module ssi_scope_decode #(
    parameter int LOCAL_CORES = 4,
    parameter int CLUSTERS    = 2,
    parameter int CLUSTER_ID  = 0,
    localparam int OWN_W  = $clog2(LOCAL_CORES),
    localparam int CORE_W = $clog2(LOCAL_CORES * CLUSTERS),
    localparam int CL_W   = CORE_W - OWN_W
) (
    input  logic [CORE_W-1:0] core_id,
    output logic              in_scope,
    output logic [OWN_W-1:0]  local_id
);
    assign local_id = core_id[OWN_W-1:0];
    assign in_scope = (core_id[CORE_W-1:OWN_W] == CL_W'(CLUSTER_ID));
endmodule

// File: rtl/ssi_sync_filter.sv
// Per-line decision: must this line be dropped on the current synchronization?
module ssi_sync_filter #(
    parameter int OWN_W = 2
) (
    input  logic             valid,
    input  logic             int_sh,
    input  logic             ext_sh,
    input  logic [OWN_W-1:0] owner,
    input  logic [OWN_W-1:0] sync_local,
    output logic             kill
);
    // Outer-private lines are safe; inner-shared lines are always suspect;
    // inner-private lines are suspect only to their owner.
    assign kill = valid && ext_sh && (int_sh || (owner == sync_local));
endmodule

// File: rtl/ssi_read_filter.sv
// Per-way lookup decision: tag match and whether the access must go upward.
module ssi_read_filter #(
    parameter int OWN_W = 2,
    parameter int TAG_W = 12
) (
    input  logic             valid,
    input  logic [TAG_W-1:0] tag,
    input  logic             int_sh,
    input  logic             ext_sh,
    input  logic [OWN_W-1:0] owner,
    input  logic [OWN_W-1:0] rd_core,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             match,
    output logic             fwd
);
    assign match = valid && (tag == rd_tag);
    assign fwd   = match && !int_sh && ext_sh && (owner != rd_core);
endmodule

// File: rtl/scope_selfinv_ctrl.sv
module scope_selfinv_ctrl
    import ssi_pkg::*;
#(
    parameter int SETS        = 16,
    parameter int WAYS        = 4,
    parameter int LOCAL_CORES = 4,
    parameter int CLUSTERS    = 2,
    parameter int CLUSTER_ID  = 0,
    parameter int TAG_W       = 12,
    localparam int SET_W  = $clog2(SETS),
    localparam int WAY_W  = $clog2(WAYS),
    localparam int OWN_W  = $clog2(LOCAL_CORES),
    localparam int CORE_W = $clog2(LOCAL_CORES * CLUSTERS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_valid,
    input  logic [SET_W-1:0]  fill_set,
    input  logic [WAY_W-1:0]  fill_way,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              fill_int_shared,
    input  logic              fill_ext_shared,
    input  logic [OWN_W-1:0]  fill_owner,
    input  logic              fill_dirty,
    input  logic              rd_valid,
    input  logic [OWN_W-1:0]  rd_core,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_ready,
    output logic              rd_ack,
    output logic [1:0]        rd_kind,
    input  logic              sync_req,
    input  logic [CORE_W-1:0] sync_core,
    output logic              sync_ready,
    output logic              sync_done,
    output logic              wb_req,
    output logic [SET_W-1:0]  wb_set,
    output logic [TAG_W-1:0]  wb_tag,
    input  logic              wb_ack
);

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             int_sh;
        logic             ext_sh;
        logic [OWN_W-1:0] owner;
        logic [TAG_W-1:0] tag;
    } line_t;

    typedef struct packed {
        scan_e                         st;
        logic [SET_W-1:0]              idx;
        logic [OWN_W-1:0]              sloc;
        logic [WAY_W-1:0]              vway;
        logic                          rack;
        rd_kind_e                      rkind;
        logic                          done;
        line_t [SETS-1:0][WAYS-1:0]    tbl;
    } state_t;

    state_t q, d;

    // Scope of an incoming synchronization
    logic             s_in;
    logic [OWN_W-1:0] s_loc;

    ssi_scope_decode #(
        .LOCAL_CORES (LOCAL_CORES),
        .CLUSTERS    (CLUSTERS),
        .CLUSTER_ID  (CLUSTER_ID)
    ) u_scope (
        .core_id  (sync_core),
        .in_scope (s_in),
        .local_id (s_loc)
    );

    // Per-way decisions for the scanned set and the looked-up set
    logic [WAYS-1:0] kill_v, dirty_v, rmatch_v, rfwd_v;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        ssi_sync_filter #(.OWN_W(OWN_W)) u_sf (
            .valid      (q.tbl[q.idx][w].valid),
            .int_sh     (q.tbl[q.idx][w].int_sh),
            .ext_sh     (q.tbl[q.idx][w].ext_sh),
            .owner      (q.tbl[q.idx][w].owner),
            .sync_local (q.sloc),
            .kill       (kill_v[w])
        );
        assign dirty_v[w] = q.tbl[q.idx][w].dirty;

        ssi_read_filter #(.OWN_W(OWN_W), .TAG_W(TAG_W)) u_rf (
            .valid   (q.tbl[rd_set][w].valid),
            .tag     (q.tbl[rd_set][w].tag),
            .int_sh  (q.tbl[rd_set][w].int_sh),
            .ext_sh  (q.tbl[rd_set][w].ext_sh),
            .owner   (q.tbl[rd_set][w].owner),
            .rd_core (rd_core),
            .rd_tag  (rd_tag),
            .match   (rmatch_v[w]),
            .fwd     (rfwd_v[w])
        );
    end

    // Lowest dirty victim in the scanned set
    logic [WAYS-1:0]  dkill_v;
    logic [WAY_W-1:0] vpick;
    assign dkill_v = kill_v & dirty_v;

    always_comb begin
        vpick = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (dkill_v[w]) vpick = WAY_W'(w);
        end
    end

    logic hit_found;

    always_comb begin
        d         = q;
        d.rack    = 1'b0;
        d.done    = 1'b0;
        hit_found = 1'b0;

        // Lookups stall on the set the scan holds
        rd_ready = !((q.st != SC_IDLE) && (rd_set == q.idx));

        if (rd_valid && rd_ready) begin
            d.rack  = 1'b1;
            d.rkind = RK_MISS;
            for (int w = 0; w < WAYS; w++) begin
                if (rmatch_v[w] && !hit_found) begin
                    hit_found = 1'b1;
                    if (rfwd_v[w]) begin
                        d.rkind                   = RK_FWD;
                        d.tbl[rd_set][w].int_sh   = 1'b1;
                        d.tbl[rd_set][w].ext_sh   = 1'b1;
                    end else begin
                        d.rkind = RK_HIT;
                    end
                end
            end
        end

        case (q.st)
            SC_IDLE: begin
                if (sync_req) begin
                    if (s_in) begin
                        d.st   = SC_SCAN;
                        d.idx  = '0;
                        d.sloc = s_loc;
                    end else begin
                        d.done = 1'b1;
                    end
                end
            end
            SC_SCAN: begin
                if (|dkill_v) begin
                    d.st   = SC_FLUSH;
                    d.vway = vpick;
                end else begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (kill_v[w]) d.tbl[q.idx][w].valid = 1'b0;
                    end
                    if (q.idx == SET_W'(SETS - 1)) begin
                        d.st   = SC_IDLE;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                    end
                end
            end
            SC_FLUSH: begin
                if (wb_ack) begin
                    d.tbl[q.idx][q.vway].valid = 1'b0;
                    d.tbl[q.idx][q.vway].dirty = 1'b0;
                    d.st                       = SC_SCAN;
                end
            end
            default: d.st = SC_IDLE;
        endcase

        if (fill_valid) begin
            d.tbl[fill_set][fill_way].valid  = 1'b1;
            d.tbl[fill_set][fill_way].dirty  = fill_dirty;
            d.tbl[fill_set][fill_way].int_sh = fill_int_shared;
            d.tbl[fill_set][fill_way].ext_sh = fill_ext_shared;
            d.tbl[fill_set][fill_way].owner  = fill_owner;
            d.tbl[fill_set][fill_way].tag    = fill_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_ack     = q.rack;
    assign rd_kind    = q.rkind;
    assign sync_ready = (q.st == SC_IDLE);
    assign sync_done  = q.done;
    assign wb_req     = (q.st == SC_FLUSH);
    assign wb_set     = q.idx;
    assign wb_tag     = q.tbl[q.idx][q.vway].tag;

endmodule

// File: rtl/ssi_checker.sv
module ssi_checker #(
    parameter int SET_W = 4,
    parameter int TAG_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_valid,
    input logic             rd_ready,
    input logic [SET_W-1:0] rd_set,
    input logic             rd_ack,
    input logic [1:0]       rd_kind,
    input logic             sync_ready,
    input logic             sync_done,
    input logic             wb_req,
    input logic             wb_ack,
    input logic [SET_W-1:0] wb_set,
    input logic [TAG_W-1:0] wb_tag
);
    AST_RD_ACK_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_ready) |=> rd_ack);                                  // R12
    AST_RD_ACK_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rd_valid && rd_ready)) |=> !rd_ack);                              // R12
    AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> (rd_kind != 2'd3));                                       // R11
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_tag) && $stable(wb_set))); // R10
    AST_WB_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_ready |-> !wb_req);                                             // R10
    AST_WB_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        wb_req |-> !(rd_ready && (rd_set == wb_set)));                       // R9
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_done |-> sync_ready);                                           // R8
endmodule

bind scope_selfinv_ctrl ssi_checker #(.SET_W(SET_W), .TAG_W(TAG_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_valid   (rd_valid),
    .rd_ready   (rd_ready),
    .rd_set     (rd_set),
    .rd_ack     (rd_ack),
    .rd_kind    (rd_kind),
    .sync_ready (sync_ready),
    .sync_done  (sync_done),
    .wb_req     (wb_req),
    .wb_ack     (wb_ack),
    .wb_set     (wb_set),
    .wb_tag     (wb_tag)
);

// File: tb/sim_scope_selfinv_ctrl.sv
module sim_scope_selfinv_ctrl;
    localparam int CLK_PERIOD  = 10;
    localparam int SETS        = 4;
    localparam int WAYS        = 2;
    localparam int LOCAL_CORES = 4;
    localparam int CLUSTERS    = 2;
    localparam int TAG_W       = 8;
    localparam int SET_W       = 2;
    localparam int WAY_W       = 1;
    localparam int OWN_W       = 2;
    localparam int CORE_W      = 3;
    localparam int K_HIT = 0, K_FWD = 1, K_MISS = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic fill_valid = 0, fill_int_shared = 0, fill_ext_shared = 0, fill_dirty = 0;
    logic [SET_W-1:0] fill_set = '0, rd_set = '0, wb_set;
    logic [WAY_W-1:0] fill_way = '0;
    logic [TAG_W-1:0] fill_tag = '0, rd_tag = '0, wb_tag;
    logic [OWN_W-1:0] fill_owner = '0, rd_core = '0;
    logic rd_valid = 0, rd_ready, rd_ack;
    logic [1:0] rd_kind;
    logic sync_req = 0, sync_ready, sync_done, wb_req, wb_ack = 0;
    logic [CORE_W-1:0] sync_core = '0;

    int n_chk = 0, n_fail = 0;

    scope_selfinv_ctrl #(
        .SETS(SETS), .WAYS(WAYS), .LOCAL_CORES(LOCAL_CORES),
        .CLUSTERS(CLUSTERS), .CLUSTER_ID(0), .TAG_W(TAG_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .fill_valid(fill_valid), .fill_set(fill_set), .fill_way(fill_way),
        .fill_tag(fill_tag), .fill_int_shared(fill_int_shared),
        .fill_ext_shared(fill_ext_shared), .fill_owner(fill_owner),
        .fill_dirty(fill_dirty),
        .rd_valid(rd_valid), .rd_core(rd_core), .rd_set(rd_set), .rd_tag(rd_tag),
        .rd_ready(rd_ready), .rd_ack(rd_ack), .rd_kind(rd_kind),
        .sync_req(sync_req), .sync_core(sync_core), .sync_ready(sync_ready),
        .sync_done(sync_done),
        .wb_req(wb_req), .wb_set(wb_set), .wb_tag(wb_tag), .wb_ack(wb_ack)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_fill(input int s, input int w, input int tg, input int ish,
                           input int esh, input int own, input int dt);
        @(negedge clk);
        fill_valid = 1'b1; fill_set = SET_W'(s); fill_way = WAY_W'(w);
        fill_tag = TAG_W'(tg); fill_int_shared = ish[0]; fill_ext_shared = esh[0];
        fill_owner = OWN_W'(own); fill_dirty = dt[0];
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_read(input int core, input int s, input int tg, output int kind);
        @(negedge clk);
        rd_valid = 1'b1; rd_core = OWN_W'(core); rd_set = SET_W'(s); rd_tag = TAG_W'(tg);
        #1;
        while (!rd_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        rd_valid = 1'b0;
        kind = rd_ack ? int'(rd_kind) : -1;
    endtask

    task automatic do_sync(input int core, output int cyc);
        @(negedge clk);
        sync_req = 1'b1; sync_core = CORE_W'(core);
        #1;
        while (!sync_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        sync_req = 1'b0;
        cyc = 1;
        while (!sync_done && cyc < 500) begin @(negedge clk); cyc++; end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R8: watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int kind, cyc, tg;
        bit kill, fwd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 sync_ready", int'(sync_ready), 1);
        chk("R1 wb_req", int'(wb_req), 0);
        chk("R1 rd_ack", int'(rd_ack), 0);
        chk("R1 sync_done", int'(sync_done), 0);
        for (int s = 0; s < SETS; s++) begin
            do_read(0, s, 0, kind);
            chk("R1 empty lookup", kind, K_MISS);
        end

        // Sweep: classification x owner x synchronizing core (both clusters)
        for (int ish = 0; ish < 2; ish++)
        for (int esh = 0; esh < 2; esh++)
        for (int own = 0; own < LOCAL_CORES; own++)
        for (int sc = 0; sc < LOCAL_CORES * CLUSTERS; sc++) begin
            tg = 8'hA0 + own;
            do_fill(1, 1, tg, ish, esh, own, 0);
            do_sync(sc, cyc);
            kill = (sc < LOCAL_CORES) && (esh == 1) && (ish == 1 || own == sc);
            if (sc >= LOCAL_CORES) chk("R7 out-of-scope done timing", cyc, 1);
            else                   chk("R8 scan done timing", cyc, SETS + 1);
            @(negedge clk);
            chk("R8 done single pulse", int'(sync_done), 0);
            do_read(own, 1, tg, kind);
            if (sc >= LOCAL_CORES)  chk("R7 out-of-scope keeps line", kind, K_HIT);
            else if (esh == 0)      chk("R2 outer-private kept", kind, K_HIT);
            else if (ish == 1)      chk("R4 shared-shared cleared", kind, K_MISS);
            else                    chk("R3 owner-only clear", kind, kill ? K_MISS : K_HIT);
        end

        // Sweep: classification x owner x reading core, then promotion
        for (int ish = 0; ish < 2; ish++)
        for (int esh = 0; esh < 2; esh++)
        for (int own = 0; own < LOCAL_CORES; own++)
        for (int rc = 0; rc < LOCAL_CORES; rc++) begin
            tg = 8'hB0 + own * 4 + rc;
            do_fill(2, 0, tg, ish, esh, own, 0);
            fwd = (ish == 0) && (esh == 1) && (rc != own);
            do_read(rc, 2, tg, kind);
            chk("R5 lookup answer", kind, fwd ? K_FWD : K_HIT);
            do_read(rc, 2, tg, kind);
            chk("R6 repeat lookup after forward", kind, K_HIT);
            do_sync((own + 1) % LOCAL_CORES, cyc);
            kill = (esh == 1) && (ish == 1 || fwd);
            do_read(own, 2, tg, kind);
            chk("R6 promoted line cleared by non-owner", kind, kill ? K_MISS : K_HIT);
        end

        // R11: way selection and misses
        do_fill(0, 0, 8'h11, 0, 0, 0, 0);
        do_fill(0, 1, 8'h22, 0, 0, 1, 0);
        do_read(0, 0, 8'h11, kind); chk("R11 way0 hit", kind, K_HIT);
        do_read(1, 0, 8'h22, kind); chk("R11 way1 hit", kind, K_HIT);
        do_read(0, 0, 8'h33, kind); chk("R11 absent tag", kind, K_MISS);
        do_read(0, 3, 8'h11, kind); chk("R11 other set", kind, K_MISS);

        // R10 / R9: dirty victim writeback with stalled acknowledge
        do_fill(3, 0, 8'h5A, 1, 1, 0, 1);
        do_fill(3, 1, 8'h6B, 1, 0, 0, 1);
        @(negedge clk);
        sync_req = 1'b1; sync_core = 3'd2;
        @(negedge clk);
        sync_req = 1'b0;
        cyc = 0;
        while (!wb_req && cyc < 50) begin @(negedge clk); cyc++; end
        chk("R10 writeback raised", int'(wb_req), 1);
        chk("R10 writeback set", int'(wb_set), 3);
        chk("R10 writeback tag", int'(wb_tag), 8'h5A);
        repeat (3) @(negedge clk);
        chk("R10 held without ack", int'(wb_req), 1);
        chk("R10 tag held", int'(wb_tag), 8'h5A);
        rd_set = 2'd3; #1;
        chk("R9 stalled set refused", int'(rd_ready), 0);
        rd_set = 2'd1; #1;
        chk("R9 other set accepted", int'(rd_ready), 1);
        @(negedge clk);
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
        begin
            int extra_wb = 0;
            cyc = 0;
            while (!sync_done && cyc < 50) begin
                if (wb_req) extra_wb++;
                @(negedge clk); cyc++;
            end
            chk("R10 clean or outer-private neighbour not written back", extra_wb, 0);
        end
        do_read(0, 3, 8'h5A, kind); chk("R10 victim cleared after ack", kind, K_MISS);
        do_read(0, 3, 8'h6B, kind); chk("R2 dirty outer-private kept", kind, K_HIT);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule